// File: doc/BRIEF.md
# Multi-Mode Retriggerable Delay Timer

This block turns a single trigger line into a timed output level. An 8-bit binary weight, a prescale choice and a 2-bit mode together set the timing. The output is high at rest. Depending on the mode, a trigger edge drives it low at once and releases it after a delay, or moves it only once the delay has run out. The four modes are: one-shot pulse, delayed operate, delayed release and dual delay. An abort input cancels any timing in progress and holds the output high. What happens when the abort is released depends on the mode and on the trigger level at that moment.

The clock must run at twice the time-base rate, so one time-base period equals two clocks. This is how the half-period offset of the three delay modes is made: those modes add one clock to the count. With weight W and prescale factor S, a one-shot pulse lasts 2·S·W clocks. The delay in every other mode is 2·S·W + 1 clocks. A count of zero is raised to one clock. The trigger and abort inputs must already be synchronous to the clock. The count length is latched when a timing run starts.

Top module: `dly_timer`

## Requirements
- R1: With mode 2'b00 (one-shot), a rising trigger edge drives `dly_out` low on the next clock. `dly_out` returns high 2·S·W clocks after that edge.
- R2: In one-shot mode, a rising edge during a pulse restarts the count from that edge. A falling trigger edge has no effect on `dly_out`.
- R3: With mode 2'b01 (delayed operate), a rising edge starts a count, and `dly_out` goes low 2·S·W+1 clocks after the edge. While the trigger is low, `dly_out` is high from the next clock on.
- R4: With mode 2'b10 (delayed release), a falling edge starts a count, and `dly_out` goes high 2·S·W+1 clocks after the edge. While the trigger is high, `dly_out` is low from the next clock on.
- R5: With mode 2'b11 (dual delay), either trigger edge starts or restarts the count. 2·S·W+1 clocks after the latest edge, `dly_out` takes the inverse of the trigger level.
- R6: After power-on reset `dly_out` is high. While `abort` is high, `dly_out` is high from the next clock on and any count in progress is dropped.
- R7: When `abort` falls with the trigger low, `dly_out` stays high in every mode. When it falls with the trigger high, the response depends on the mode. Delayed operate and dual delay start a count and go low after 2·S·W+1 clocks. Delayed release goes low on the next clock. One-shot stays high.
- R8: `psel` picks S: 2'b00 gives 1, 2'b01 gives SCALE_A, 2'b10 gives SCALE_B, and 2'b11 gives 1.
- R9: With W = 0, a one-shot pulse is low for exactly one clock, and the other modes act one clock after the edge.
- R10: `weight` and `psel` are sampled when a count starts. Later changes do not alter that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, twice the time-base rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort | input | 1 | High: cancel timing, hold output high |
| trig | input | 1 | Synchronous trigger level |
| mode | input | 2 | 00 one-shot, 01 delayed operate, 10 delayed release, 11 dual delay |
| psel | input | 2 | Prescale factor select |
| weight | input | WEIGHT_W | Binary-weighted delay count W |
| dly_out | output | 1 | Timed output, high at rest |

## Verification
The bench builds the timer with SCALE_A = 3 and SCALE_B = 5 instead of the line-rate factors. This puts every prescale choice, including the reserved code, within a few dozen clocks. Exact pulse and delay edges can then be checked one clock before and one clock after they are due. Because the runs are this short, a single test can also fit retriggers, mid-run aborts, abort release at both trigger levels, and changes to the weight during a run.

// File: rtl/dly_timer.sv
module dly_timer #(
  parameter int WEIGHT_W = 8,
  parameter int SCALE_A  = 3000,
  parameter int SCALE_B  = 3600
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                abort,
  input  logic                trig,
  input  logic [1:0]          mode,
  input  logic [1:0]          psel,
  input  logic [WEIGHT_W-1:0] weight,
  output logic                dly_out
);
  localparam logic [1:0] M_OS = 2'b00;
  localparam logic [1:0] M_DO = 2'b01;
  localparam logic [1:0] M_DR = 2'b10;
  localparam logic [1:0] M_DD = 2'b11;
  localparam int SMAX  = (SCALE_A > SCALE_B) ? SCALE_A : SCALE_B;
  localparam int CNT_W = WEIGHT_W + $clog2(SMAX + 1) + 2;

  logic             trig_q, abort_q, running, out_q;
  logic [CNT_W-1:0] cnt, tgt, scale, span, span_adj, lim;
  logic             start, stop, out_n;

  wire rise       = trig & ~trig_q;
  wire fall       = ~trig & trig_q;
  wire abort_fall = ~abort & abort_q;
  wire fire       = running && (cnt == tgt - CNT_W'(1));

  always_comb begin
    case (psel)
      2'b01:   scale = CNT_W'(SCALE_A);
      2'b10:   scale = CNT_W'(SCALE_B);
      default: scale = CNT_W'(1);
    endcase
  end

  assign span     = (scale * CNT_W'(weight)) << 1;
  assign span_adj = span + CNT_W'(mode != M_OS);
  assign lim      = (span_adj == '0) ? CNT_W'(1) : span_adj;

  always_comb begin
    start = 1'b0;
    stop  = 1'b0;
    out_n = out_q;
    if (abort) begin
      stop  = 1'b1;
      out_n = 1'b1;
    end else if (abort_fall) begin
      if (trig) begin
        case (mode)
          M_DO, M_DD: start = 1'b1;
          M_DR:       out_n = 1'b0;
          default:    ;
        endcase
      end
    end else begin
      case (mode)
        M_OS: begin
          if (rise) begin
            start = 1'b1;
            out_n = 1'b0;
          end else if (fire) begin
            stop  = 1'b1;
            out_n = 1'b1;
          end
        end
        M_DO: begin
          if (!trig) begin
            stop  = 1'b1;
            out_n = 1'b1;
          end else if (rise) begin
            start = 1'b1;
          end else if (fire) begin
            stop  = 1'b1;
            out_n = 1'b0;
          end
        end
        M_DR: begin
          if (trig) begin
            stop  = 1'b1;
            out_n = 1'b0;
          end else if (fall) begin
            start = 1'b1;
          end else if (fire) begin
            stop  = 1'b1;
            out_n = 1'b1;
          end
        end
        default: begin
          if (rise || fall) begin
            start = 1'b1;
          end else if (fire) begin
            stop  = 1'b1;
            out_n = ~trig;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= 1'b0;
      abort_q <= 1'b0;
      running <= 1'b0;
      out_q   <= 1'b1;
      cnt     <= '0;
      tgt     <= CNT_W'(1);
    end else begin
      trig_q  <= trig;
      abort_q <= abort;
      out_q   <= out_n;
      if (start) begin
        running <= 1'b1;
        cnt     <= '0;
        tgt     <= lim;
      end else if (stop) begin
        running <= 1'b0;
        cnt     <= '0;
      end else if (running) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign dly_out = out_q;
endmodule

// File: rtl/dly_timer_chk.sv
module dly_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       abort,
  input logic       trig,
  input logic [1:0] mode,
  input logic       dly_out
);
  p_abort_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> dly_out);

  p_do_trig_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort && mode == 2'b01 && !trig) |=> dly_out);

  p_dr_trig_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort && mode == 2'b10 && trig) |=> !dly_out);

  p_os_rise_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort && !$past(abort) && mode == 2'b00 && $rose(trig)) |=> !dly_out);

  p_os_fall_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort && mode == 2'b00 && $fell(trig) && dly_out) |=> dly_out);

  p_os_release_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && $fell(abort)) |=> dly_out);
endmodule

bind dly_timer dly_timer_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .abort  (abort),
  .trig   (trig),
  .mode   (mode),
  .dly_out(dly_out)
);

// File: tb/sim_dly_timer.sv
`timescale 1ns/1ps
module sim_dly_timer;
  localparam int SA = 3;
  localparam int SB = 5;
  localparam int NV = 10;
  // {mode[15:14], psel[13:12], weight[11:4], init trig[3], before[2], after[1], pad[0]}
  localparam logic [15:0] VEC [NV] = '{
    {2'b00, 2'b00, 8'd5, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'b00, 2'b01, 8'd2, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'b01, 2'b10, 8'd1, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'b01, 2'b11, 8'd6, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'b10, 2'b00, 8'd7, 1'b1, 1'b0, 1'b1, 1'b0},
    {2'b10, 2'b01, 8'd1, 1'b1, 1'b0, 1'b1, 1'b0},
    {2'b11, 2'b00, 8'd3, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'b11, 2'b10, 8'd2, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'b00, 2'b00, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'b01, 2'b00, 8'd0, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       abort = 1'b0;
  logic       trig = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [1:0] psel = 2'b00;
  logic [7:0] weight = 8'd0;
  logic       dly_out;
  int         n_chk = 0;
  int         n_bad = 0;

  always #10 clk = ~clk;

  dly_timer #(.WEIGHT_W(8), .SCALE_A(SA), .SCALE_B(SB)) u0 (
    .clk(clk), .rst_n(rst_n), .abort(abort), .trig(trig),
    .mode(mode), .psel(psel), .weight(weight), .dly_out(dly_out)
  );

  function automatic int exp_len(logic [1:0] m, logic [1:0] p, logic [7:0] w);
    int s;
    int t;
    s = (p == 2'b01) ? SA : (p == 2'b10) ? SB : 1;
    t = 2 * s * int'(w) + ((m != 2'b00) ? 1 : 0);
    return (t == 0) ? 1 : t;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: dly_out=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic arm(logic [1:0] m, logic [1:0] p, logic [7:0] w, logic t);
    @(negedge clk);
    mode = m; psel = p; weight = w; trig = t; abort = 1'b1;
    tick(2);
    abort = 1'b0;
    tick(3);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    int          d;
    string       tag;
    tick(3);
    check("R6 reset", dly_out, 1'b1);
    rst_n = 1'b1;
    tick(2);
    check("R6 reset", dly_out, 1'b1);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      arm(v[15:14], v[13:12], v[11:4], v[3]);
      d = exp_len(v[15:14], v[13:12], v[11:4]);
      if (v[11:4] == 8'd0) tag = "R9";
      else if (v[13:12] != 2'b00) tag = "R8";
      else if (v[15:14] == 2'b00) tag = "R1";
      else if (v[15:14] == 2'b01) tag = "R3";
      else if (v[15:14] == 2'b10) tag = "R4";
      else tag = "R5";
      trig = ~v[3];
      tick(d);
      check(tag, dly_out, v[2]);
      tick(1);
      check(tag, dly_out, v[1]);
    end

    // R2: falling edge ignored, rising edge restarts (T=10)
    arm(2'b00, 2'b00, 8'd5, 1'b0);
    trig = 1'b1; tick(4);
    trig = 1'b0; tick(2);
    check("R2 fall", dly_out, 1'b0);
    trig = 1'b1; tick(5);
    check("R2 restart", dly_out, 1'b0);
    tick(5);
    check("R2 restart", dly_out, 1'b0);
    tick(1);
    check("R2 restart", dly_out, 1'b1);

    // R5: dual delay restart and falling-edge timeout (T=5)
    arm(2'b11, 2'b00, 8'd2, 1'b0);
    trig = 1'b1; tick(3);
    trig = 1'b0; tick(1);
    trig = 1'b1; tick(2);
    check("R5 restart", dly_out, 1'b1);
    tick(3);
    check("R5 rise", dly_out, 1'b1);
    tick(1);
    check("R5 rise", dly_out, 1'b0);
    trig = 1'b0; tick(5);
    check("R5 fall", dly_out, 1'b0);
    tick(1);
    check("R5 fall", dly_out, 1'b1);

    // R6 + R7: abort mid pulse in one-shot, release with trig high
    arm(2'b00, 2'b00, 8'd5, 1'b0);
    trig = 1'b1; tick(4);
    abort = 1'b1; tick(1);
    check("R6 abort", dly_out, 1'b1);
    tick(9);
    abort = 1'b0; tick(1);
    check("R7 os", dly_out, 1'b1);
    tick(10);
    check("R7 os", dly_out, 1'b1);

    // R6 + R7: delayed operate, abort cancels, release starts new count (T=11)
    arm(2'b01, 2'b00, 8'd5, 1'b0);
    trig = 1'b1; tick(4);
    abort = 1'b1; tick(10);
    check("R6 cancel", dly_out, 1'b1);
    abort = 1'b0; tick(11);
    check("R7 do", dly_out, 1'b1);
    tick(1);
    check("R7 do", dly_out, 1'b0);

    // R7: dual delay release with trig high (T=3)
    @(negedge clk);
    mode = 2'b11; psel = 2'b00; weight = 8'd1; trig = 1'b0; abort = 1'b1;
    tick(1); trig = 1'b1; tick(2);
    abort = 1'b0; tick(3);
    check("R7 dd", dly_out, 1'b1);
    tick(1);
    check("R7 dd", dly_out, 1'b0);

    // R7: delayed release, trig high, low at once
    @(negedge clk);
    mode = 2'b10; abort = 1'b1; trig = 1'b1;
    tick(2);
    check("R6 abort", dly_out, 1'b1);
    abort = 1'b0; tick(1);
    check("R7 dr", dly_out, 1'b0);

    // R7: release with trig low stays high
    @(negedge clk);
    mode = 2'b11; trig = 1'b0; abort = 1'b1;
    tick(2);
    abort = 1'b0; tick(8);
    check("R7 low", dly_out, 1'b1);

    // R10: weight and psel changes during a run are not used (T=8)
    arm(2'b00, 2'b00, 8'd4, 1'b0);
    trig = 1'b1; tick(2);
    weight = 8'd20; psel = 2'b01; tick(6);
    check("R10", dly_out, 1'b0);
    tick(1);
    check("R10", dly_out, 1'b1);

    finish_run();
  end
endmodule